// File: doc/BRIEF.md
# Dual Wiper Register Write Controller

This block sits behind a two-wire serial target front end that has already framed the bus traffic. It sees a start pulse, a stop pulse and one strobe per received byte. From that stream it decodes a fixed three-byte write command: a target address, then an instruction, then a data byte. The command updates the tap position of one of two digital potentiometers. For every byte it returns an acknowledge decision, which the front end drives onto the bus.

Each potentiometer has a live wiper register and a shadow register that stands in for non-volatile storage. Both are plain flops. A volatile write changes only the wiper. A non-volatile write changes the wiper and the shadow. A recall pulse, which models power coming back, copies each shadow into its wiper. Data above the top tap is clamped to the top tap. A write-enable latch must be set before any write is allowed.

The decoder is a five-state machine:
- `S_IDLE`: waits for a start.
- `S_ADDR`: expects the address byte.
- `S_INSTR`: expects the instruction byte.
- `S_DATA`: expects the data byte.
- `S_DRAIN`: refuses every further byte until the next start or stop.

Its transitions are:
- start → `S_ADDR` from any state.
- stop → `S_IDLE` from any state.
- address match → `S_INSTR`; mismatch → `S_DRAIN`.
- valid instruction → `S_DATA`; invalid → `S_DRAIN`.
- data byte → `S_DRAIN`.

Top module: `wiper_write_ctrl`

## Requirements
- R1: Once a transaction is under way, the first byte is acknowledged only if it equals 8'hAE. Any other value is refused, and every later byte of that transaction is refused with no register change.
- R2: The second byte is acknowledged only if bits 6:2 equal 5'b01000 and the select field in bits 1:0 is 2'b00 (potentiometer 1, 100 taps) or 2'b01 (potentiometer 2, 256 taps). Select codes 2'b10 and 2'b11 and any other pattern in bits 6:2 are refused, and the following data byte changes nothing.
- R3: With the enable latch set, a data byte is acknowledged. Its value appears on the selected wiper output at the clock edge that samples its strobe. Bytes after the data byte are refused and ignored.
- R4: Instruction bit 7 = 0 gives a volatile write: only the wiper changes, and the shadow keeps its earlier value.
- R5: Instruction bit 7 = 1 gives a non-volatile write: the wiper and the shadow both take the value.
- R6: Potentiometer 1 takes data values 0 to 98 as they are and clamps any value of 99 or above to 99. Potentiometer 2 maps all 256 values one to one. No value wraps.
- R7: While the enable latch is clear, the data byte is refused and neither wiper nor shadow changes. A set pulse sets the latch and a clear pulse clears it.
- R8: A recall pulse loads each wiper from its shadow at the next clock edge.
- R9: A start or stop before the data byte abandons the transaction with no register change. Bytes that arrive outside a transaction are refused.
- R10: One cycle after every byte strobe, `ack_vld_o` is high for exactly one cycle together with the decision on `ack_o`.
- R11: After reset both wipers and both shadows are 0, the latch is clear and no acknowledge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start-condition pulse |
| stop_i | input | 1 | One-cycle stop-condition pulse |
| byte_vld_i | input | 1 | One-cycle strobe: a complete byte is on `byte_i` |
| byte_i | input | 8 | Received byte |
| recall_i | input | 1 | Power-up recall pulse: shadows are copied into the wipers |
| wel_set_i | input | 1 | Sets the write-enable latch |
| wel_clr_i | input | 1 | Clears the write-enable latch |
| ack_vld_o | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| wiper1_o | output | 7 | Tap of potentiometer 1 (0 to 99) |
| wiper2_o | output | 8 | Tap of potentiometer 2 (0 to 255) |

## Verification
The shadow registers have no port, so showing that a volatile write left a shadow alone is the hardest thing to observe. The bench first stores a known value with a non-volatile write. It then overwrites the wiper with a volatile write and pulses recall. The wiper must return to the stored value, not keep the volatile one. Abandoned transactions are driven the same way: a start or stop is inserted before the data byte, and the bench then confirms that the wiper still holds its previous value.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_INSTR,
        S_DATA,
        S_DRAIN
    } dec_state_t;

    localparam logic [4:0] INSTR_FIXED = 5'b01000;
endpackage

// File: rtl/wdc_decoder.sv
module wdc_decoder
    import wdc_pkg::*;
#(
    parameter logic [7:0] TARGET_ADDR = 8'hAE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       wel_i,
    output logic       ack_vld_o,
    output logic       ack_o,
    output logic       wr_en_o,
    output logic       wr_sel_o,
    output logic       wr_nv_o,
    output logic [7:0] wr_data_o
);
    dec_state_t state_q, state_d;
    logic       sel_q, nv_q;
    logic       take_byte, addr_hit, instr_ok, byte_ack;

    assign take_byte = byte_vld_i && !start_i && !stop_i;
    assign addr_hit  = (byte_i == TARGET_ADDR);
    assign instr_ok  = (byte_i[6:2] == INSTR_FIXED) && !byte_i[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= 1'b0;
            nv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_byte && state_q == S_INSTR && instr_ok) begin
                sel_q <= byte_i[0];
                nv_q  <= byte_i[7];
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = S_ADDR;
        end else if (stop_i) begin
            state_d = S_IDLE;
        end else if (byte_vld_i) begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_ADDR:  state_d = addr_hit ? S_INSTR : S_DRAIN;
                S_INSTR: state_d = instr_ok ? S_DATA : S_DRAIN;
                S_DATA:  state_d = S_DRAIN;
                S_DRAIN: state_d = S_DRAIN;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        byte_ack = 1'b0;
        if (take_byte) begin
            unique case (state_q)
                S_ADDR:  byte_ack = addr_hit;
                S_INSTR: byte_ack = instr_ok;
                S_DATA:  byte_ack = wel_i;
                default: byte_ack = 1'b0;
            endcase
        end
    end

    assign wr_en_o   = take_byte && (state_q == S_DATA) && wel_i;
    assign wr_sel_o  = sel_q;
    assign wr_nv_o   = nv_q;
    assign wr_data_o = byte_i;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld_o <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            ack_vld_o <= byte_vld_i;
            ack_o     <= byte_ack;
        end
    end

    p_ack_follows_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_i |=> ack_vld_o);
    p_ack_only_when_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vld_o);
    p_bad_addr_drains_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && state_q == S_ADDR && !addr_hit) |=> (state_q == S_DRAIN) && !ack_o);
    p_drain_refuses_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN) |-> !wr_en_o);
    p_reserved_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && state_q == S_INSTR && byte_i[1]) |=> (ack_vld_o && !ack_o));
    p_stop_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state_q == S_IDLE));
    p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == S_ADDR));
endmodule

// File: rtl/wdc_wiper_reg.sv
module wdc_wiper_reg #(
    parameter int TAPS = 100,
    localparam int W   = $clog2(TAPS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic         wr_nv_i,
    input  logic [7:0]   wr_data_i,
    input  logic         recall_i,
    output logic [W-1:0] wiper_o
);
    localparam logic [7:0] TOP = 8'(TAPS - 1);

    logic [W-1:0] shadow_q, wiper_q, clamped;

    assign clamped = (wr_data_i >= TOP) ? TOP[W-1:0] : wr_data_i[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q  <= '0;
            shadow_q <= '0;
        end else if (recall_i) begin
            wiper_q <= shadow_q;
        end else if (wr_en_i) begin
            wiper_q <= clamped;
            if (wr_nv_i) begin
                shadow_q <= clamped;
            end
        end
    end

    assign wiper_o = wiper_q;

    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        {{(8-W){1'b0}}, wiper_q} <= TOP);
    p_volatile_keeps_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_nv_i) |=> $stable(shadow_q));
    p_nv_sets_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_nv_i && !recall_i) |=> (shadow_q == wiper_q));
    p_recall_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recall_i |=> (wiper_q == $past(shadow_q)));
endmodule

// File: rtl/wiper_write_ctrl.sv
module wiper_write_ctrl #(
    parameter logic [7:0] TARGET_ADDR = 8'hAE,
    parameter int         TAPS1       = 100,
    parameter int         TAPS2       = 256,
    localparam int        W1          = $clog2(TAPS1),
    localparam int        W2          = $clog2(TAPS2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic          recall_i,
    input  logic          wel_set_i,
    input  logic          wel_clr_i,
    output logic          ack_vld_o,
    output logic          ack_o,
    output logic [W1-1:0] wiper1_o,
    output logic [W2-1:0] wiper2_o
);
    logic       wel_q;
    logic       wr_en, wr_sel, wr_nv;
    logic [7:0] wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wel_q <= 1'b0;
        else if (wel_set_i) wel_q <= 1'b1;
        else if (wel_clr_i) wel_q <= 1'b0;
    end

    wdc_decoder #(.TARGET_ADDR(TARGET_ADDR)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .wel_i      (wel_q),
        .ack_vld_o  (ack_vld_o),
        .ack_o      (ack_o),
        .wr_en_o    (wr_en),
        .wr_sel_o   (wr_sel),
        .wr_nv_o    (wr_nv),
        .wr_data_o  (wr_data)
    );

    wdc_wiper_reg #(.TAPS(TAPS1)) u_pot1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en && !wr_sel),
        .wr_nv_i   (wr_nv),
        .wr_data_i (wr_data),
        .recall_i  (recall_i),
        .wiper_o   (wiper1_o)
    );

    wdc_wiper_reg #(.TAPS(TAPS2)) u_pot2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en && wr_sel),
        .wr_nv_i   (wr_nv),
        .wr_data_i (wr_data),
        .recall_i  (recall_i),
        .wiper_o   (wiper2_o)
    );

    p_write_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel_q && !recall_i) |=> ($stable(wiper1_o) && $stable(wiper2_o)));
endmodule

// File: tb/tb_wiper_write_ctrl.sv
module tb_wiper_write_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       recall_i = 1'b0, wel_set_i = 1'b0, wel_clr_i = 1'b0;
    logic       ack_vld_o, ack_o;
    logic [6:0] wiper1_o;
    logic [7:0] wiper2_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wiper_write_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .recall_i(recall_i),
        .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i), .ack_vld_o(ack_vld_o),
        .ack_o(ack_o), .wiper1_o(wiper1_o), .wiper2_o(wiper2_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic pulse_recall();
        @(negedge clk) recall_i = 1'b1;
        @(negedge clk) recall_i = 1'b0;
    endtask

    task automatic set_latch(input logic on);
        @(negedge clk) begin wel_set_i = on; wel_clr_i = !on; end
        @(negedge clk) begin wel_set_i = 1'b0; wel_clr_i = 1'b0; end
    endtask

    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_vld_i = 1'b0;
        check(ack_vld_o, 1, {tag, " R10 ack_vld"});
        check(ack_o, exp_ack, tag);
        @(negedge clk);
        check(ack_vld_o, 0, {tag, " R10 single pulse"});
    endtask

    task automatic write_cmd(input logic [7:0] instr, input logic [7:0] data, input logic exp_dack,
                             input string tag);
        pulse_start();
        send(8'hAE, 1'b1, {tag, " R1 addr"});
        send(instr, 1'b1, {tag, " R2 instr"});
        send(data, exp_dack, {tag, " R3 data"});
        pulse_stop();
    endtask

    task automatic t_reset();
        check(ack_vld_o, 0, "R11 ack_vld");
        check(wiper1_o, 0, "R11 wiper1");
        check(wiper2_o, 0, "R11 wiper2");
        pulse_recall();
        check(wiper1_o, 0, "R11 shadow1");
        check(wiper2_o, 0, "R11 shadow2");
    endtask

    task automatic t_latch_clear();
        write_cmd(8'hA0, 8'd30, 1'b0, "R7 locked");
        check(wiper1_o, 0, "R7 wiper1 untouched");
        pulse_recall();
        check(wiper1_o, 0, "R7 shadow untouched");
        set_latch(1'b1);
    endtask

    task automatic t_volatile();
        write_cmd(8'h20, 8'd42, 1'b1, "R4 vol");
        check(wiper1_o, 42, "R3 wiper1 written");
        pulse_recall();
        check(wiper1_o, 0, "R4 shadow kept / R8 recall");
    endtask

    task automatic t_nonvolatile();
        write_cmd(8'hA1, 8'd200, 1'b1, "R5 nv");
        check(wiper2_o, 200, "R5 wiper2");
        write_cmd(8'h21, 8'd5, 1'b1, "R4 vol2");
        check(wiper2_o, 5, "R4 wiper2 volatile");
        pulse_recall();
        check(wiper2_o, 200, "R5 shadow2 / R8 recall");
    endtask

    task automatic t_clamp();
        write_cmd(8'hA0, 8'd99, 1'b1, "R6 99");
        check(wiper1_o, 99, "R6 at 99");
        write_cmd(8'h20, 8'd98, 1'b1, "R6 98");
        check(wiper1_o, 98, "R6 at 98");
        write_cmd(8'h20, 8'd100, 1'b1, "R6 100");
        check(wiper1_o, 99, "R6 100 clamps");
        write_cmd(8'h20, 8'hFF, 1'b1, "R6 FF");
        check(wiper1_o, 99, "R6 FF no wrap");
        write_cmd(8'h21, 8'hFF, 1'b1, "R6 pot2 FF");
        check(wiper2_o, 255, "R6 pot2 one to one");
        pulse_recall();
        check(wiper1_o, 99, "R6 clamped shadow1");
        check(wiper2_o, 200, "R8 shadow2 kept");
    endtask

    task automatic t_bad_addr();
        pulse_start();
        send(8'hAF, 1'b0, "R1 wrong addr");
        send(8'h20, 1'b0, "R1 instr after bad addr");
        send(8'd7, 1'b0, "R1 data after bad addr");
        pulse_stop();
        check(wiper1_o, 99, "R1 wiper1 unchanged");
    endtask

    task automatic t_bad_instr();
        pulse_start();
        send(8'hAE, 1'b1, "R2 addr");
        send(8'h22, 1'b0, "R2 reserved select 10");
        send(8'd3, 1'b0, "R2 data refused");
        pulse_stop();
        pulse_start();
        send(8'hAE, 1'b1, "R2 addr b");
        send(8'h23, 1'b0, "R2 reserved select 11");
        pulse_stop();
        pulse_start();
        send(8'hAE, 1'b1, "R2 addr c");
        send(8'h28, 1'b0, "R2 wrong fixed bits");
        send(8'd4, 1'b0, "R2 data refused c");
        pulse_stop();
        check(wiper1_o, 99, "R2 wiper1 unchanged");
        check(wiper2_o, 200, "R2 wiper2 unchanged");
    endtask

    task automatic t_abort();
        pulse_start();
        send(8'hAE, 1'b1, "R9 addr");
        send(8'h21, 1'b1, "R9 instr");
        pulse_stop();
        send(8'd9, 1'b0, "R9 byte outside transaction");
        check(wiper2_o, 200, "R9 stop abort");
        pulse_start();
        send(8'hAE, 1'b1, "R9 addr b");
        send(8'h20, 1'b1, "R9 instr b");
        pulse_start();
        send(8'd11, 1'b0, "R9 restart treats byte as address");
        pulse_stop();
        check(wiper1_o, 99, "R9 start abort");
    endtask

    task automatic t_trailing();
        pulse_start();
        send(8'hAE, 1'b1, "R3 addr");
        send(8'h20, 1'b1, "R3 instr");
        send(8'd12, 1'b1, "R3 data");
        check(wiper1_o, 12, "R3 written before stop");
        send(8'd13, 1'b0, "R3 extra byte refused");
        pulse_stop();
        check(wiper1_o, 12, "R3 extra byte ignored");
        set_latch(1'b0);
        write_cmd(8'h20, 8'd50, 1'b0, "R7 relocked");
        check(wiper1_o, 12, "R7 clear latch blocks");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_clear();
        t_volatile();
        t_nonvolatile();
        t_clamp();
        t_bad_addr();
        t_bad_instr();
        t_abort();
        t_trailing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule